// File: doc/BRIEF.md
# Gated State Capture and Byte Readout Controller

This block acquires a 32-bit word from a bank of probe channels on every cycle of the sample clock (nominally 20 MHz, one word per 50 ns) and writes each word to an external word-wide memory through a plain address, write-data and strobe interface. Acquisition is controlled by an asynchronous start input. A rising edge of that input opens a capture, and the capture runs for as long as the input stays high. It closes when the input drops, or when a fixed window of `WINDOW_WORDS` words (one second of samples by default) has been filled, whichever comes first. The block records how many words were captured.

When the capture closes, the block raises a ready flag toward a slower host. The host then drains the buffer one byte at a time by toggling its own readout clock. That clock is unrelated to the sample clock, so the block synchronizes it, detects its rising edges in the sample clock domain, and steps a 4:1 byte selector across each stored word. It fetches the next word from memory after the fourth byte. Readout stops at the last captured word, and the ready flag then falls. While the host holds the block in reset, it neither captures nor reads.

Top module: `tcap_capture_top`

## Requirements
- R1: While `rst_n` is low, `mem_we_o`, `mem_re_o` and `ready_o` stay low, and activity on `start_i` leads to no capture once reset is released with `start_i` low.
- R2: A capture writes one word per sample clock to consecutive addresses starting at 0. The first stored word is the value of `probe_i` at the second rising clock edge after `start_i` is first sampled high, and each following word is the next clock's sample.
- R3: When `start_i` is sampled high on N consecutive clock edges and N is below `WINDOW_WORDS`, exactly N words are written. A capture with N = 1 stores a single word.
- R4: If `start_i` stays high, a capture stops after exactly `WINDOW_WORDS` words.
- R5: `ready_o` rises after a capture ends and stays high until readout completes.
- R6: While `ready_o` is high, `byte_o` presents one byte of the current word. Lane 0 is bits 7:0, followed by 15:8, 23:16 and 31:24. Each synchronized rising edge of `host_clk_i` advances to the next lane, and after lane 3 it advances to lane 0 of the next address.
- R7: Readout covers exactly the captured word count, and `ready_o` falls after the host edge that consumes lane 3 of the last captured word.
- R8: A rising edge of `start_i` during a capture or while `ready_o` is high is ignored: no memory write occurs while `ready_o` is high. A new capture needs a fresh rising edge after `ready_o` has fallen.
- R9: `mem_we_o` and `mem_re_o` are never high together, and reads happen only while `ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Host reset, active low, asynchronous assert |
| start_i | input | 1 | Asynchronous capture gate; high while logging is wanted |
| probe_i | input | DATA_W | Probe channels sampled each clock |
| host_clk_i | input | 1 | Asynchronous host readout clock; each rising edge consumes one byte |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_we_o | output | 1 | Memory write strobe |
| mem_re_o | output | 1 | Memory read strobe; data is expected on `mem_rdata_i` one clock later |
| mem_rdata_i | input | DATA_W | Memory read data |
| byte_o | output | 8 | Byte currently offered to the host |
| ready_o | output | 1 | Captured data is waiting to be read |

## Verification
The probe bus carries a free-running count, so every stored word shows by its value which clock it was sampled on. An offset, a skipped sample or a repeated sample then appears as a wrong byte at readout. Captures are run at three lengths: a single sample, a short gate that closes before the window, and a long gate that runs into the window cap. These separate the stop-on-gate path from the stop-on-cap path and show that the stored word count bounds readout. In one readout the start input is dropped and raised again, to show that it neither writes memory nor disturbs the bytes being drained.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CAPT  = 3'd1,
        ST_FETCH = 3'd2,
        ST_LOAD  = 3'd3,
        ST_SERVE = 3'd4
    } tcap_state_e;

endpackage

// File: rtl/tcap_sync.sv
module tcap_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [STAGES-1:0][WIDTH-1:0] ff_d;
    logic [STAGES-1:0][WIDTH-1:0] ff_q;

    always_comb begin
        ff_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            ff_d[i] = ff_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ff_q <= '0;
        end else begin
            ff_q <= ff_d;
        end
    end

    assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/tcap_rise.sv
module tcap_rise (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o
);
    logic prev_d;
    logic prev_q;

    always_comb begin
        prev_d = lvl_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= prev_d;
        end
    end

    assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/tcap_byte_sel.sv
module tcap_byte_sel #(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    localparam int LANES = DATA_W / BYTE_W,
    localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [DATA_W-1:0] word_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic [BYTE_W-1:0] byte_o
);
    logic [LANES-1:0][BYTE_W-1:0] lane;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane[g] = word_i[g*BYTE_W +: BYTE_W];
    end

    assign byte_o = lane[sel_i];
endmodule

// File: rtl/tcap_capture_top.sv
module tcap_capture_top
    import tcap_pkg::*;
#(
    parameter int DATA_W       = 32,
    parameter int ADDR_W       = 25,
    parameter int WINDOW_WORDS = 20_000_000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] probe_i,
    input  logic              host_clk_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic              mem_we_o,
    output logic              mem_re_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic [7:0]        byte_o,
    output logic              ready_o
);
    localparam int BYTE_W = 8;
    localparam int LANES  = DATA_W / BYTE_W;
    localparam int SEL_W  = (LANES > 1) ? $clog2(LANES) : 1;
    localparam logic [ADDR_W-1:0] WIN       = ADDR_W'(WINDOW_WORDS);
    localparam logic [SEL_W-1:0]  LAST_LANE = SEL_W'(LANES - 1);

    typedef struct packed {
        tcap_state_e       st;
        logic [ADDR_W-1:0] ptr;
        logic [ADDR_W-1:0] len;
        logic [SEL_W-1:0]  sel;
        logic [DATA_W-1:0] word;
        logic [DATA_W-1:0] probe;
        logic              ready;
    } regs_t;

    regs_t r_d;
    regs_t r_q;

    logic start_lvl;
    logic start_rise;
    logic host_lvl;
    logic host_rise;

    tcap_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_sync_start (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (start_i),
        .q_o   (start_lvl)
    );

    tcap_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_sync_host (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (host_clk_i),
        .q_o   (host_lvl)
    );

    tcap_rise u_rise_start (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (start_lvl),
        .rise_o (start_rise)
    );

    tcap_rise u_rise_host (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (host_lvl),
        .rise_o (host_rise)
    );

    tcap_byte_sel #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_byte_sel (
        .word_i (r_q.word),
        .sel_i  (r_q.sel),
        .byte_o (byte_o)
    );

    always_comb begin
        r_d       = r_q;
        r_d.probe = probe_i;
        mem_we_o  = 1'b0;
        mem_re_o  = 1'b0;

        case (r_q.st)
            ST_IDLE: begin
                // ptr is zero here, so the first word lands at address 0
                if (start_rise) begin
                    mem_we_o = 1'b1;
                    r_d.ptr  = r_q.ptr + 1'b1;
                    r_d.st   = ST_CAPT;
                end
            end
            ST_CAPT: begin
                if (start_lvl && (r_q.ptr < WIN)) begin
                    mem_we_o = 1'b1;
                    r_d.ptr  = r_q.ptr + 1'b1;
                end else begin
                    r_d.len   = r_q.ptr;
                    r_d.ptr   = '0;
                    r_d.sel   = '0;
                    r_d.ready = 1'b1;
                    r_d.st    = ST_FETCH;
                end
            end
            ST_FETCH: begin
                mem_re_o = 1'b1;
                r_d.st   = ST_LOAD;
            end
            ST_LOAD: begin
                r_d.word = mem_rdata_i;
                r_d.st   = ST_SERVE;
            end
            ST_SERVE: begin
                if (host_rise) begin
                    if (r_q.sel == LAST_LANE) begin
                        r_d.sel = '0;
                        if (r_q.ptr + 1'b1 == r_q.len) begin
                            r_d.ptr   = '0;
                            r_d.ready = 1'b0;
                            r_d.st    = ST_IDLE;
                        end else begin
                            r_d.ptr = r_q.ptr + 1'b1;
                            r_d.st  = ST_FETCH;
                        end
                    end else begin
                        r_d.sel = r_q.sel + 1'b1;
                    end
                end
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_addr_o  = r_q.ptr;
    assign mem_wdata_o = r_q.probe;
    assign ready_o     = r_q.ready;
endmodule

// File: rtl/tcap_capture_chk.sv
module tcap_capture_chk #(
    parameter int ADDR_W       = 25,
    parameter int WINDOW_WORDS = 20_000_000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_we_o,
    input logic              mem_re_o,
    input logic              ready_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              host_rise
);
    localparam logic [ADDR_W-1:0] WIN = ADDR_W'(WINDOW_WORDS);

    always @(posedge clk) begin
        if (!rst_n) begin
            AST_QUIET_IN_RESET: assert (!mem_we_o && !mem_re_o && !ready_o); // R1
        end
    end

    AST_WRITE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && $past(mem_we_o)) |-> (mem_addr_o == $past(mem_addr_o) + 1'b1)); // R2

    AST_WRITE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> (mem_addr_o < WIN)); // R4

    AST_READY_AFTER_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> $past(mem_we_o, 2)); // R5

    AST_READY_FALL_ON_HOST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready_o) |-> $past(host_rise)); // R7

    AST_NO_WRITE_WHILE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> !mem_we_o); // R8

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we_o && mem_re_o)); // R9

    AST_READ_ONLY_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re_o |-> ready_o); // R9
endmodule

bind tcap_capture_top tcap_capture_chk #(
    .ADDR_W       (ADDR_W),
    .WINDOW_WORDS (WINDOW_WORDS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_we_o   (mem_we_o),
    .mem_re_o   (mem_re_o),
    .ready_o    (ready_o),
    .mem_addr_o (mem_addr_o),
    .host_rise  (host_rise)
);

// File: tb/tcap_capture_top_bench.sv
module tcap_capture_top_bench;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 25;
    localparam int WIN    = 16;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              start_i;
    logic [DATA_W-1:0] probe_i = 32'h1000_0000;
    logic              host_clk_i;
    logic [ADDR_W-1:0] mem_addr_o;
    logic [DATA_W-1:0] mem_wdata_o;
    logic              mem_we_o;
    logic              mem_re_o;
    logic [DATA_W-1:0] mem_rdata_i = '0;
    logic [7:0]        byte_o;
    logic              ready_o;

    int vectors     = 0;
    int miscompares = 0;
    int wr_total    = 0;
    int wr_base     = 0;
    int addr_errs   = 0;
    int wr_ready    = 0;
    int both_strobe = 0;

    logic [7:0]        exp_q[$];
    logic [DATA_W-1:0] mem [0:63];

    always #5 clk = ~clk;

    tcap_capture_top #(
        .DATA_W       (DATA_W),
        .ADDR_W       (ADDR_W),
        .WINDOW_WORDS (WIN),
        .SYNC_STAGES  (2)
    ) u_tcap_capture_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .probe_i     (probe_i),
        .host_clk_i  (host_clk_i),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .mem_we_o    (mem_we_o),
        .mem_re_o    (mem_re_o),
        .mem_rdata_i (mem_rdata_i),
        .byte_o      (byte_o),
        .ready_o     (ready_o)
    );

    // probe bus: free-running count, one step per clock
    always @(negedge clk) probe_i <= probe_i + 1;

    // memory model and write monitor
    always @(posedge clk) begin
        if (mem_we_o) begin
            mem[mem_addr_o[5:0]] <= mem_wdata_o;
            if (int'(mem_addr_o) != wr_total - wr_base) addr_errs++;
            if (ready_o) wr_ready++;
            wr_total++;
        end
        if (mem_re_o) mem_rdata_i <= mem[mem_addr_o[5:0]];
        if (mem_we_o && mem_re_o) both_strobe++;
    end

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // driver: gate the capture for h clock edges, push expected bytes
    task automatic capture(input int h);
        logic [DATA_W-1:0] p;
        int n;
        @(negedge clk);
        wr_base = wr_total;
        start_i = 1'b1;
        p = probe_i;
        n = (h < WIN) ? h : WIN;
        for (int k = 0; k < n; k++) begin
            logic [DATA_W-1:0] w;
            w = p + DATA_W'(2 + k);
            for (int b = 0; b < 4; b++) exp_q.push_back(w[b*8 +: 8]);
        end
        repeat (h) @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 200; i++) begin
            if (ready_o) break;
            @(negedge clk);
        end
    endtask

    // monitor: drains the design one byte per host pulse and compares
    task automatic drain(input bit poke);
        int idx;
        idx = 0;
        while (exp_q.size() > 0) begin
            logic [7:0] e;
            e = exp_q.pop_front();
            repeat (10) @(negedge clk);
            chk(byte_o == e, "R6 byte", {24'd0, byte_o}, {24'd0, e});
            if (poke && idx == 3) start_i = 1'b0;
            if (poke && idx == 6) start_i = 1'b1;
            host_clk_i = 1'b1;
            repeat (8) @(negedge clk);
            host_clk_i = 1'b0;
            if (exp_q.size() > 0) chk(ready_o == 1'b1, "R5 ready held", {31'd0, ready_o}, 32'd1);
            idx++;
        end
        repeat (10) @(negedge clk);
        chk(ready_o == 1'b0, "R7 ready falls after last byte", {31'd0, ready_o}, 32'd0);
    endtask

    task automatic run_case(input int h, input bit poke, input string tag);
        int n;
        n = (h < WIN) ? h : WIN;
        capture(h);
        wait_ready();
        chk(ready_o == 1'b1, "R5 ready after capture", {31'd0, ready_o}, 32'd1);
        chk(wr_total - wr_base == n, tag, wr_total - wr_base, n);
        chk(addr_errs == 0, "R2 consecutive addresses", addr_errs, 0);
        drain(poke);
        if (poke) begin
            start_i = 1'b0;
            repeat (10) @(negedge clk);
            chk(wr_total - wr_base == n, "R8 no capture from start during readout",
                wr_total - wr_base, n);
        end
        chk(wr_ready == 0, "R8 no write while ready", wr_ready, 0);
        chk(both_strobe == 0, "R9 strobes exclusive", both_strobe, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL R7 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        rst_n      = 1'b0;
        start_i    = 1'b0;
        host_clk_i = 1'b0;
        repeat (3) @(negedge clk);
        chk(ready_o == 1'b0, "R1 ready in reset", {31'd0, ready_o}, 32'd0);
        chk(mem_we_o == 1'b0, "R1 write strobe in reset", {31'd0, mem_we_o}, 32'd0);
        start_i = 1'b1;
        repeat (6) @(negedge clk);
        chk(wr_total == 0, "R1 start ignored in reset", wr_total, 0);
        chk(ready_o == 1'b0, "R1 ready stays low", {31'd0, ready_o}, 32'd0);
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk(wr_total == 0, "R1 no capture after release", wr_total, 0);

        run_case(5, 1'b0, "R3 gate of 5 edges");
        run_case(30, 1'b1, "R4 capped at window");
        run_case(1, 1'b0, "R3 single sample");
        run_case(WIN - 1, 1'b0, "R3 one below window");

        summary();
        $finish;
    end
endmodule